// File: doc/BRIEF.md
# Sector Data Field Write Sequencer

This block produces the byte stream of one sector's data field while a sector is being written. A start pulse tells it that the header trailer has just passed. It then counts a fixed number of byte times of gap before it opens the write gate. Inside the gate it sends a run of zero bytes for synchronisation, then a mark byte. The mark is either the ordinary data mark or the deleted-data mark, chosen by a flag sampled with the start pulse. After the mark come the payload bytes, which it takes one at a time from the controller. Next come two check bytes, a CRC-16 that it computes itself while the field goes out. A trailing zero byte ends the field, and then the gate closes.

Every byte boundary is given by a byte-time tick from the serializer. The serializer is outside this block, and so is the encoding onto the medium. At each tick the block loads the next byte into its output register and holds it there until the next tick. Payload bytes are taken with a valid/acknowledge exchange. If the controller has no byte ready when one is due, a zero byte goes out in its place and a sticky underrun flag is raised.

Top module: `fdw_data_field_writer`

## Requirements
- R1: After an accepted start, `wr_gate_o` stays low through the first GAP_BYTES-1 ticks (10 by default) and rises on the GAP_BYTES-th tick (11th). Ticks with no start never raise the gate.
- R2: The first PRE_BYTES (6) bytes inside the gate are 0x00.
- R3: The next byte is the mark: 0xF8 when `delete_i` was high in the start cycle, otherwise 0xFB. `delete_i` is ignored at every other time. `mark_o` is high exactly while the mark byte is on `wr_byte_o`.
- R4: The next DATA_BYTES (128) bytes are controller bytes, one per tick, in order. `host_ack_o` is high, in the same cycle as the tick, only for a tick that takes a payload byte while `host_valid_i` is high.
- R5: Two check bytes follow, high byte first. They hold the CRC-16 with polynomial 0x1021, preset 0xFFFF, fed MSB first, over the mark byte and all payload bytes as written.
- R6: POST_BYTES (1) byte of 0x00 follows. On the next tick `wr_gate_o` falls and `done_o` pulses high for exactly one cycle.
- R7: A payload tick with `host_valid_i` low writes 0x00, which also enters the CRC, and sets `underrun_o`. `underrun_o` stays high until the next accepted start.
- R8: A start pulse while a field is in progress is ignored. The byte sequence and its timing are unchanged.
- R9: While `rst_n` is low, all outputs are 0 and the block is idle. A reset in mid-field abandons the field.
- R10: `wr_byte_o` changes only on a clock edge at which `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse: header trailer has passed |
| delete_i | input | 1 | Use the deleted-data mark; sampled with start |
| tick_i | input | 1 | One-cycle pulse per byte time |
| host_data_i | input | 8 | Payload byte offered by the controller |
| host_valid_i | input | 1 | Payload byte is ready |
| host_ack_o | output | 1 | Payload byte taken this cycle |
| wr_byte_o | output | 8 | Byte being written |
| mark_o | output | 1 | Current byte is the mark |
| wr_gate_o | output | 1 | Write gate |
| done_o | output | 1 | One-cycle pulse when the field is complete |
| underrun_o | output | 1 | A payload byte was missing in this field |

## Verification
The bench builds the block with its default layout: an 11-byte gap, 6 preamble bytes, 128 payload bytes and 1 postamble byte. This makes the exact 138-byte field and its check bytes visible over full-length payloads. The bench varies the number of idle cycles between ticks, so the hold-between-ticks behaviour and the combinational acknowledge are seen at several spacings. Its stimulus places a missing payload byte at the first payload position, the last payload position and a middle position, and a field with no missing byte after one with a hole shows that the underrun flag clears. It also repeats starts during the gap and during the payload, and resets in mid-field.

// File: rtl/fdw_pkg.sv
package fdw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_GAP,
        PH_PRE,
        PH_MARK,
        PH_DATA,
        PH_CRC,
        PH_POST
    } phase_e;

    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;
    localparam logic [7:0]  MARK_NORMAL = 8'hFB;
    localparam logic [7:0]  MARK_DELETED = 8'hF8;

    // Phase that follows a completed phase.
    function automatic phase_e phase_after(input phase_e ph);
        phase_e nx;
        unique case (ph)
            PH_GAP:  nx = PH_PRE;
            PH_PRE:  nx = PH_MARK;
            PH_MARK: nx = PH_DATA;
            PH_DATA: nx = PH_CRC;
            PH_CRC:  nx = PH_POST;
            default: nx = PH_IDLE;
        endcase
        return nx;
    endfunction

    // Byte-wide CRC update, MSB of the byte first.
    function automatic logic [15:0] crc16_step(input logic [15:0] crc_in, input logic [7:0] b);
        logic [15:0] c;
        c = crc_in;
        for (int i = 7; i >= 0; i--) begin
            if (c[15] ^ b[i]) begin
                c = {c[14:0], 1'b0} ^ CRC_POLY;
            end else begin
                c = {c[14:0], 1'b0};
            end
        end
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fdw_phase_seq.sv
module fdw_phase_seq
    import fdw_pkg::*;
#(
    parameter int GAP_BYTES  = 11,
    parameter int PRE_BYTES  = 6,
    parameter int DATA_BYTES = 128,
    parameter int POST_BYTES = 1,
    parameter int CNT_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             tick_i,
    output phase_e           phase_o,
    output phase_e           nxt_phase_o,
    output logic [CNT_W-1:0] nxt_cnt_o,
    output logic             adv_o,
    output logic             accept_o,
    output logic             done_o
);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W-1:0] lim;

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        adv_o       = 1'b0;
        accept_o    = 1'b0;
        nxt_phase_o = s_q.phase;
        nxt_cnt_o   = s_q.cnt;

        unique case (s_q.phase)
            PH_GAP:  lim = CNT_W'(GAP_BYTES - 1);
            PH_PRE:  lim = CNT_W'(PRE_BYTES - 1);
            PH_DATA: lim = CNT_W'(DATA_BYTES - 1);
            PH_CRC:  lim = CNT_W'(1);
            PH_POST: lim = CNT_W'(POST_BYTES - 1);
            default: lim = '0;
        endcase

        if (s_q.phase == PH_IDLE) begin
            if (start_i) begin
                accept_o  = 1'b1;
                s_d.phase = PH_GAP;
                s_d.cnt   = '0;
            end
        end else if (tick_i) begin
            adv_o = 1'b1;
            if (s_q.cnt == lim) begin
                nxt_phase_o = phase_after(s_q.phase);
                nxt_cnt_o   = '0;
            end else begin
                nxt_cnt_o = s_q.cnt + 1'b1;
            end
            s_d.phase = nxt_phase_o;
            s_d.cnt   = nxt_cnt_o;
            if (nxt_phase_o == PH_IDLE) begin
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.phase;
    assign done_o  = s_q.done;

    // R8: while busy and no tick arrives, nothing moves, even on a start pulse
    a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase != PH_IDLE && !tick_i) |=> (s_q.phase == $past(s_q.phase) && s_q.cnt == $past(s_q.cnt)));

    // R6: the done pulse only follows the last postamble tick
    a_r6_done_after_post: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> ($past(s_q.phase) == PH_POST && $past(tick_i)));

endmodule

// File: rtl/fdw_crc16.sv
module fdw_crc16
    import fdw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear_i,
    input  logic        en_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] crc_o
);

    logic [15:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear_i) begin
            crc_d = CRC_INIT;
        end else if (en_i) begin
            crc_d = crc16_step(crc_q, byte_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_INIT;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc_o = crc_q;

    // R5: the register is preset to all ones at every accepted start
    a_r5_crc_preset: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (crc_q == 16'hFFFF));

endmodule

// File: rtl/fdw_byte_path.sv
module fdw_byte_path
    import fdw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept_i,
    input  logic        delete_i,
    input  logic        adv_i,
    input  phase_e      nxt_phase_i,
    input  logic        crc_hi_i,
    input  logic [7:0]  host_data_i,
    input  logic        host_valid_i,
    input  logic [15:0] crc_i,
    output logic        crc_en_o,
    output logic [7:0]  crc_byte_o,
    output logic        ack_o,
    output logic [7:0]  wr_byte_o,
    output logic        mark_o,
    output logic        underrun_o
);

    typedef struct packed {
        logic [7:0] wbyte;
        logic       mark;
        logic       del;
        logic       under;
    } bp_t;

    bp_t  s_d, s_q;
    logic [7:0] fill;

    always_comb begin
        s_d = s_q;

        unique case (nxt_phase_i)
            PH_MARK: fill = s_q.del ? MARK_DELETED : MARK_NORMAL;
            PH_DATA: fill = host_valid_i ? host_data_i : 8'h00;
            PH_CRC:  fill = crc_hi_i ? crc_i[15:8] : crc_i[7:0];
            default: fill = 8'h00;
        endcase

        crc_en_o   = adv_i && (nxt_phase_i == PH_MARK || nxt_phase_i == PH_DATA);
        crc_byte_o = fill;
        ack_o      = adv_i && (nxt_phase_i == PH_DATA) && host_valid_i;

        if (accept_i) begin
            s_d.del   = delete_i;
            s_d.under = 1'b0;
        end

        if (adv_i) begin
            s_d.wbyte = fill;
            s_d.mark  = (nxt_phase_i == PH_MARK);
            if (nxt_phase_i == PH_DATA && !host_valid_i) begin
                s_d.under = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{wbyte: 8'h00, mark: 1'b0, del: 1'b0, under: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_byte_o  = s_q.wbyte;
    assign mark_o     = s_q.mark;
    assign underrun_o = s_q.under;

    // R3: the mark flag always carries one of the two mark codes
    a_r3_mark_code: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.mark |-> (s_q.wbyte == 8'hFB || s_q.wbyte == 8'hF8));

    // R7: a missing payload byte goes out as zero
    a_r7_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && nxt_phase_i == PH_DATA && !host_valid_i) |=> (s_q.wbyte == 8'h00 && s_q.under));

endmodule

// File: rtl/fdw_data_field_writer.sv
module fdw_data_field_writer
    import fdw_pkg::*;
#(
    parameter int GAP_BYTES  = 11,
    parameter int PRE_BYTES  = 6,
    parameter int DATA_BYTES = 128,
    parameter int POST_BYTES = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       delete_i,
    input  logic       tick_i,
    input  logic [7:0] host_data_i,
    input  logic       host_valid_i,
    output logic       host_ack_o,
    output logic [7:0] wr_byte_o,
    output logic       mark_o,
    output logic       wr_gate_o,
    output logic       done_o,
    output logic       underrun_o
);

    localparam int LONGEST = max2(max2(GAP_BYTES, PRE_BYTES), max2(max2(DATA_BYTES, POST_BYTES), 2));
    localparam int CNT_W   = $clog2(LONGEST + 1);

    phase_e           phase, nxt_phase;
    logic [CNT_W-1:0] nxt_cnt;
    logic             adv, accept;
    logic             crc_en;
    logic [7:0]       crc_byte;
    logic [15:0]      crc;

    fdw_phase_seq #(
        .GAP_BYTES (GAP_BYTES),
        .PRE_BYTES (PRE_BYTES),
        .DATA_BYTES(DATA_BYTES),
        .POST_BYTES(POST_BYTES),
        .CNT_W     (CNT_W)
    ) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .tick_i     (tick_i),
        .phase_o    (phase),
        .nxt_phase_o(nxt_phase),
        .nxt_cnt_o  (nxt_cnt),
        .adv_o      (adv),
        .accept_o   (accept),
        .done_o     (done_o)
    );

    fdw_crc16 i_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(accept),
        .en_i   (crc_en),
        .byte_i (crc_byte),
        .crc_o  (crc)
    );

    fdw_byte_path i_bytes (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .delete_i    (delete_i),
        .adv_i       (adv),
        .nxt_phase_i (nxt_phase),
        .crc_hi_i    (nxt_cnt == '0),
        .host_data_i (host_data_i),
        .host_valid_i(host_valid_i),
        .crc_i       (crc),
        .crc_en_o    (crc_en),
        .crc_byte_o  (crc_byte),
        .ack_o       (host_ack_o),
        .wr_byte_o   (wr_byte_o),
        .mark_o      (mark_o),
        .underrun_o  (underrun_o)
    );

    assign wr_gate_o = (phase == PH_PRE) || (phase == PH_MARK) || (phase == PH_DATA) ||
                       (phase == PH_CRC) || (phase == PH_POST);

    // R1: the gate opens only on a byte tick
    a_r1_gate_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_gate_o) |-> $past(tick_i));

    // R3: the mark flag is only seen inside the gate
    a_r3_mark_in_gate: assert property (@(posedge clk) disable iff (!rst_n)
        mark_o |-> wr_gate_o);

    // R4: acknowledge only with a tick, a ready byte and an open gate
    a_r4_ack_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack_o |-> (tick_i && host_valid_i && wr_gate_o));

    // R6: done comes with the gate already closed
    a_r6_done_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wr_gate_o);

    // R7: the underrun flag clears only on a start
    a_r7_underrun_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(underrun_o) |-> $past(start_i));

    // R10: the output byte holds between ticks
    a_r10_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(wr_byte_o));

endmodule

// File: tb/test_fdw_data_field_writer.sv
module test_fdw_data_field_writer;

    localparam int GAP_N   = 11;
    localparam int PRE_N   = 6;
    localparam int DATA_N  = 128;
    localparam int POST_N  = 1;
    localparam int FIELD_N = PRE_N + 1 + DATA_N + 2 + POST_N;

    typedef struct packed {
        logic       del;
        logic [7:0] seed;
        logic [7:0] hole;     // payload index left missing; 255 = none
        logic [3:0] idle;     // extra idle cycles between ticks
        logic [7:0] restart;  // tick number carrying a stray start; 0 = none
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{del: 1'b0, seed: 8'h11, hole: 8'd60,  idle: 4'd0, restart: 8'd0},
        '{del: 1'b1, seed: 8'h5A, hole: 8'd255, idle: 4'd2, restart: 8'd0},
        '{del: 1'b0, seed: 8'hC3, hole: 8'd0,   idle: 4'd1, restart: 8'd4},
        '{del: 1'b1, seed: 8'h07, hole: 8'd127, idle: 4'd3, restart: 8'd70},
        '{del: 1'b0, seed: 8'hFF, hole: 8'd255, idle: 4'd0, restart: 8'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       del = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] hdata = 8'h00;
    logic       hvalid = 1'b0;
    logic       ack, mark, gate, done, under;
    logic [7:0] wbyte;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fdw_data_field_writer i_fdw_data_field_writer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .delete_i    (del),
        .tick_i      (tick),
        .host_data_i (hdata),
        .host_valid_i(hvalid),
        .host_ack_o  (ack),
        .wr_byte_o   (wbyte),
        .mark_o      (mark),
        .wr_gate_o   (gate),
        .done_o      (done),
        .underrun_o  (under)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_ref(input logic [15:0] c_in, input logic [7:0] b);
        logic [15:0] c;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            c = (c[15] ^ b[i]) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
        end
        return c;
    endfunction

    function automatic logic [7:0] hbyte(input logic [7:0] seed, input int i);
        return seed ^ 8'(i * 29 + 3);
    endfunction

    function automatic string req_of(input int k);
        if (k < PRE_N) return "R2";
        if (k == PRE_N) return "R3";
        if (k < PRE_N + 1 + DATA_N) return "R4";
        if (k < PRE_N + 3 + DATA_N) return "R5";
        return "R6";
    endfunction

    task automatic run_frame(input vec_t v);
        logic [7:0]  ex [FIELD_N];
        logic [15:0] c;
        logic [7:0]  last;
        int          k, i;
        bit          exp_ack;
        for (int j = 0; j < FIELD_N; j++) ex[j] = 8'h00;
        ex[PRE_N] = v.del ? 8'hF8 : 8'hFB;
        for (int j = 0; j < DATA_N; j++) ex[PRE_N + 1 + j] = (j == int'(v.hole)) ? 8'h00 : hbyte(v.seed, j);
        c = 16'hFFFF;
        for (int j = PRE_N; j < PRE_N + 1 + DATA_N; j++) c = crc_ref(c, ex[j]);
        ex[PRE_N + 1 + DATA_N] = c[15:8];
        ex[PRE_N + 2 + DATA_N] = c[7:0];

        @(negedge clk);
        start = 1'b1;
        del   = v.del;
        @(negedge clk);
        start = 1'b0;
        del   = ~v.del;   // R3: must not matter after the start cycle
        last  = wbyte;
        for (int t = 1; t <= GAP_N + FIELD_N; t++) begin
            for (int w = 0; w < int'(v.idle); w++) begin
                @(negedge clk);
                chk(wbyte == last, "R10", "byte held between ticks", 32'(wbyte), 32'(last));
            end
            @(negedge clk);
            chk(wbyte == last, "R10", "byte held before tick", 32'(wbyte), 32'(last));
            k = t - GAP_N;
            i = k - (PRE_N + 1);
            tick   = 1'b1;
            hvalid = (i != int'(v.hole));
            hdata  = (i >= 0 && i < DATA_N) ? hbyte(v.seed, i) : 8'hA5;
            if (t == int'(v.restart)) begin
                start = 1'b1;   // R8: stray start while busy
                del   = ~del;
            end
            #1;
            exp_ack = (i >= 0) && (i < DATA_N) && (i != int'(v.hole));
            chk(ack == exp_ack, "R4", "acknowledge", 32'(ack), 32'(exp_ack));
            @(negedge clk);
            tick   = 1'b0;
            start  = 1'b0;
            hvalid = 1'b0;
            if (k < 0) begin
                chk(!gate, "R1", "gate during gap", 32'(gate), 0);
            end else if (k < FIELD_N) begin
                chk(gate, req_of(k), "gate inside field", 32'(gate), 1);
                chk(wbyte == ex[k], req_of(k), $sformatf("byte %0d", k), 32'(wbyte), 32'(ex[k]));
                chk(mark == (k == PRE_N), "R3", "mark flag", 32'(mark), 32'(k == PRE_N));
            end else begin
                chk(!gate, "R6", "gate after field", 32'(gate), 0);
                chk(done, "R6", "done pulse", 32'(done), 1);
            end
            last = wbyte;
        end
        @(negedge clk);
        chk(!done, "R6", "done is one cycle", 32'(done), 0);
        chk(under == (int'(v.hole) < DATA_N), "R7", "underrun flag", 32'(under), 32'(int'(v.hole) < DATA_N));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(!gate && !mark && !done && !ack && !under, "R9", "flags in reset",
            {27'd0, gate, mark, done, ack, under}, 0);
        chk(wbyte == 8'h00, "R9", "byte in reset", 32'(wbyte), 0);
        rst_n = 1'b1;

        // R1: ticks with no start never open the gate
        for (int n = 0; n < 15; n++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            chk(!gate && wbyte == 8'h00, "R1", "idle tick", {23'd0, gate, wbyte}, 0);
        end

        for (int vi = 0; vi < 5; vi++) begin
            run_frame(VECS[vi]);
        end

        // R9: reset in mid-field abandons the field
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start  = 1'b0;
        hvalid = 1'b1;
        hdata  = 8'h3C;
        for (int n = 0; n < 30; n++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
        chk(gate, "R9", "gate open before reset", 32'(gate), 1);
        rst_n = 1'b0;
        #1;
        chk(!gate && !mark && !done && wbyte == 8'h00, "R9", "outputs after mid-field reset",
            {21'd0, gate, mark, done, wbyte}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            chk(!gate, "R9", "idle after reset", 32'(gate), 0);
        end
        hvalid = 1'b0;
        run_frame(VECS[1]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule